// File: doc/BRIEF.md
# Speculative Store Buffer with Commit and Rollback

This block sits between a load/store unit and memory and holds guest stores that are not yet final. Stores enter in program order with an address, a data word and byte enables. They are kept in a circular FIFO that is split by a movable boundary. Entries older than the boundary are committed and drain to memory in order over a valid/ready write port. Entries younger than the boundary are speculative. As a result, memory only ever sees committed stores.

Two strobes from outside decide the fate of speculative entries. A commit strobe moves the boundary up to the youngest buffered store. A rollback strobe throws away every speculative entry in a single cycle and leaves memory untouched by them. Loads probe the buffer at the same time. If one or more entries hold the load address, the youngest of them supplies the data, whether it is committed or not. If none does, the load reads from memory.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty` is 1, `full` is 0, `memValid` is 0 and `stReady` is 1.
- R2: An accepted store that has not been committed is never offered on the memory port; `memValid` stays 0 while only speculative entries are held.
- R3: After `commitReq`, every previously accepted store drains in acceptance order with its address, data and byte enables. While `memValid` is 1 and `memReady` is 0, the memory port outputs hold steady.
- R4: `rollbackReq` removes all speculative entries in one cycle. Committed entries are kept and still drain.
- R5: When `commitReq` and `rollbackReq` are both 1 in a cycle, rollback wins and the speculative entries are discarded.
- R6: A store accepted in the same cycle as `commitReq` stays speculative.
- R7: With DEPTH entries held, `full` is 1 and `stReady` is 0. A waiting store is held off rather than dropped, and it is accepted once a drain frees an entry.
- R8: A load whose address equals that of a held entry gets `ldHit`=1, plus the data and byte enables of the youngest such entry, committed or not. Without a match, `ldHit`, `ldData` and `ldBe` are 0.
- R9: `stReady` is 0 in any cycle where `rollbackReq` is 1.
- R10: `empty` is 1 exactly when no entry is held, and `memValid` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store request present |
| stReady | output | 1 | Store can be accepted this cycle |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| stBe | input | DATA_W/8 | Store byte enables |
| commitReq | input | 1 | Commit all buffered stores |
| rollbackReq | input | 1 | Discard all speculative stores |
| ldAddr | input | ADDR_W | Load probe address |
| ldHit | output | 1 | A buffered store matches the load |
| ldData | output | DATA_W | Forwarded data of youngest match |
| ldBe | output | DATA_W/8 | Byte enables of youngest match |
| memValid | output | 1 | Committed store offered to memory |
| memReady | input | 1 | Memory accepts the offered store |
| memAddr | output | ADDR_W | Drained store address |
| memData | output | DATA_W | Drained store data |
| memBe | output | DATA_W/8 | Drained store byte enables |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held |

## Verification
The bench builds the buffer with DEPTH 4, 8-bit addresses and 16-bit data, which gives two byte-enable lanes. Four stores are enough to fill the buffer, so the stall and the later acceptance of a held-off store both come within reach. The same small depth makes the read pointer wrap during the longer drain runs. With 16-bit data, different byte-enable patterns can be seen on the forwarding and drain paths.

// File: rtl/store_buffer_pkg.sv
`timescale 1ns/1ps
package store_buffer_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } sbStrobe_t;
endpackage

// File: rtl/store_buffer_ctrl.sv
`timescale 1ns/1ps
module store_buffer_ctrl
  import store_buffer_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             commitReq,
  input  logic             rollbackReq,
  input  logic             memReady,
  output logic             stReady,
  output logic             memValid,
  output logic             full,
  output logic             empty,
  output sbStrobe_t        strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic [PTR_W-1:0] liveCount
);
  logic [PTR_W-1:0] headPtr, commitPtr, tailPtr;
  logic [PTR_W-1:0] headNext, commitNext, tailNext;

  assign liveCount = tailPtr - headPtr;
  assign full      = (liveCount == PTR_W'(DEPTH));
  assign empty     = (liveCount == '0);
  assign memValid  = (commitPtr != headPtr);
  assign stReady   = !full && !rollbackReq;
  assign strobe.push = stValid && stReady;
  assign strobe.pop  = memValid && memReady;
  assign wrIdx = tailPtr[IDX_W-1:0];
  assign rdIdx = headPtr[IDX_W-1:0];

  always_comb begin
    headNext   = headPtr + PTR_W'(strobe.pop);
    commitNext = commitPtr;
    tailNext   = tailPtr + PTR_W'(strobe.push);
    if (rollbackReq) begin
      tailNext = commitPtr;
    end else if (commitReq) begin
      commitNext = tailPtr;  // same-cycle store stays speculative
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      commitPtr <= '0;
      tailPtr   <= '0;
    end else begin
      headPtr   <= headNext;
      commitPtr <= commitNext;
      tailPtr   <= tailNext;
    end
  end
endmodule

// File: rtl/store_buffer_data.sv
`timescale 1ns/1ps
module store_buffer_data
  import store_buffer_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  sbStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [PTR_W-1:0]  liveCount,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BE_W-1:0]   stBe,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic [BE_W-1:0]   ldBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [BE_W-1:0]   memBe
);
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [BE_W-1:0]   beQ   [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrQ[wrIdx] <= stAddr;
      dataQ[wrIdx] <= stData;
      beQ[wrIdx]   <= stBe;
    end
  end

  assign memAddr = addrQ[rdIdx];
  assign memData = dataQ[rdIdx];
  assign memBe   = beQ[rdIdx];

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    ldHit  = 1'b0;
    ldData = '0;
    ldBe   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [IDX_W-1:0] slot;
      slot = rdIdx + IDX_W'(i);
      if ((PTR_W'(i) < liveCount) && (addrQ[slot] == ldAddr)) begin
        ldHit  = 1'b1;
        ldData = dataQ[slot];
        ldBe   = beQ[slot];
      end
    end
  end
endmodule

// File: rtl/store_buffer.sv
`timescale 1ns/1ps
module store_buffer
  import store_buffer_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BE_W-1:0]   stBe,
  input  logic              commitReq,
  input  logic              rollbackReq,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic [BE_W-1:0]   ldBe,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [BE_W-1:0]   memBe,
  output logic              full,
  output logic              empty
);
  sbStrobe_t        strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [PTR_W-1:0] liveCount;

  store_buffer_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .clk(clk), .rstN(rstN), .stValid(stValid), .commitReq(commitReq),
    .rollbackReq(rollbackReq), .memReady(memReady), .stReady(stReady),
    .memValid(memValid), .full(full), .empty(empty), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .liveCount(liveCount)
  );

  store_buffer_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dataI (
    .clk(clk), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .liveCount(liveCount), .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .ldAddr(ldAddr), .ldHit(ldHit), .ldData(ldData), .ldBe(ldBe),
    .memAddr(memAddr), .memData(memData), .memBe(memBe)
  );
endmodule

// File: rtl/store_buffer_chk.sv
`timescale 1ns/1ps
module store_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              commitReq,
  input logic              rollbackReq,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic [BE_W-1:0]   memBe,
  input logic              full,
  input logic              empty
);
  // R7
  full_blocks_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stReady);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData) && $stable(memBe)));

  // R10
  empty_no_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !memValid);

  // R9
  rollback_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollbackReq |-> !stReady);

  // R2
  spec_not_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && stValid && stReady && !commitReq) |=> !memValid);

  // R4
  rollback_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rollbackReq && !memValid) |=> empty);
endmodule

bind store_buffer store_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
  .commitReq(commitReq), .rollbackReq(rollbackReq), .memValid(memValid),
  .memReady(memReady), .memAddr(memAddr), .memData(memData), .memBe(memBe),
  .full(full), .empty(empty)
);

// File: tb/store_buffer_test.sv
`timescale 1ns/1ps
module store_buffer_test;
  localparam int DEPTH = 4, ADDR_W = 8, DATA_W = 16, BE_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic stValid = 1'b0, commitReq = 1'b0, rollbackReq = 1'b0, memReady = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0, ldAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic [BE_W-1:0]   stBe = '0;
  logic stReady, ldHit, memValid, full, empty;
  logic [DATA_W-1:0] ldData, memData;
  logic [BE_W-1:0]   ldBe, memBe;
  logic [ADDR_W-1:0] memAddr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stBe(stBe), .commitReq(commitReq),
    .rollbackReq(rollbackReq), .ldAddr(ldAddr), .ldHit(ldHit),
    .ldData(ldData), .ldBe(ldBe), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .memBe(memBe), .full(full),
    .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stBe = be;
    @(posedge clk); #1;
    stValid = 1'b0;
  endtask

  task automatic pulse(input logic c, input logic r);
    @(negedge clk);
    commitReq = c; rollbackReq = r;
    @(posedge clk); #1;
    commitReq = 1'b0; rollbackReq = 1'b0;
  endtask

  task automatic drainExpect(input string req, input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    chk(req, memValid, 1);
    chk(req, memAddr, a);
    chk(req, memData, d);
    chk(req, memBe, be);
    memReady = 1'b1;
    @(posedge clk); #1;
    memReady = 1'b0;
  endtask

  task automatic loadExpect(input string req, input logic [7:0] a, input logic hit,
                            input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    ldAddr = a; #1;
    chk(req, ldHit, hit);
    chk(req, ldData, d);
    chk(req, ldBe, be);
  endtask

  task automatic testReset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 memValid", memValid, 0);
    chk("R1 stReady", stReady, 1);
  endtask

  task automatic testCommitDrain();
    doStore(8'h11, 16'hA001, 2'b11);
    doStore(8'h12, 16'hA002, 2'b01);
    @(negedge clk);
    chk("R2 held", memValid, 0);
    chk("R10 not empty", empty, 0);
    pulse(1, 0);
    // hold the port for a cycle with memReady low
    @(negedge clk);
    chk("R3 held addr", memAddr, 8'h11);
    drainExpect("R3 first", 8'h11, 16'hA001, 2'b11);
    drainExpect("R3 second", 8'h12, 16'hA002, 2'b01);
    @(negedge clk);
    chk("R10 empty after", empty, 1);
    chk("R10 no valid", memValid, 0);
  endtask

  task automatic testRollback();
    doStore(8'h21, 16'hB001, 2'b10);
    pulse(1, 0);
    doStore(8'h22, 16'hB002, 2'b11);
    doStore(8'h23, 16'hB003, 2'b11);
    @(negedge clk);
    rollbackReq = 1'b1; #1;
    chk("R9 stReady", stReady, 0);
    @(posedge clk); #1;
    rollbackReq = 1'b0;
    drainExpect("R4 kept", 8'h21, 16'hB001, 2'b10);
    @(negedge clk);
    chk("R4 discarded", empty, 1);
    chk("R4 no drain", memValid, 0);
  endtask

  task automatic testPriority();
    doStore(8'h31, 16'hC001, 2'b11);
    pulse(1, 1);
    @(negedge clk);
    chk("R5 rollback wins", empty, 1);
    chk("R5 no drain", memValid, 0);
  endtask

  task automatic testCommitSameCycle();
    @(negedge clk);
    stValid = 1'b1; stAddr = 8'h41; stData = 16'hD001; stBe = 2'b11; commitReq = 1'b1;
    @(posedge clk); #1;
    stValid = 1'b0; commitReq = 1'b0;
    @(negedge clk);
    chk("R6 speculative", memValid, 0);
    chk("R6 held", empty, 0);
    pulse(0, 1);
    @(negedge clk);
    chk("R6 discarded", empty, 1);
  endtask

  task automatic testFull();
    for (int i = 0; i < DEPTH; i++) doStore(8'h50 + 8'(i), 16'hE000 + 16'(i), 2'b11);
    @(negedge clk);
    chk("R7 full", full, 1);
    chk("R7 stReady", stReady, 0);
    stValid = 1'b1; stAddr = 8'h5F; stData = 16'hE0FF; stBe = 2'b01;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 still full", full, 1);
    pulse(1, 0);
    drainExpect("R7 drain first", 8'h50, 16'hE000, 2'b11);
    @(posedge clk); #1;
    stValid = 1'b0;
    chk("R7 accepted", full, 1);
    pulse(1, 0);
    for (int i = 1; i < DEPTH; i++) drainExpect("R7 order", 8'h50 + 8'(i), 16'hE000 + 16'(i), 2'b11);
    drainExpect("R7 late store", 8'h5F, 16'hE0FF, 2'b01);
    @(negedge clk);
    chk("R7 empty", empty, 1);
  endtask

  task automatic testForward();
    doStore(8'h10, 16'h1111, 2'b11);
    doStore(8'h20, 16'h2222, 2'b10);
    pulse(1, 0);
    doStore(8'h10, 16'h3333, 2'b01);
    loadExpect("R8 youngest", 8'h10, 1, 16'h3333, 2'b01);
    loadExpect("R8 committed", 8'h20, 1, 16'h2222, 2'b10);
    loadExpect("R8 miss", 8'h30, 0, 16'h0, 2'b00);
    pulse(0, 1);
    loadExpect("R8 after rollback", 8'h10, 1, 16'h1111, 2'b11);
    drainExpect("R8 drain a", 8'h10, 16'h1111, 2'b11);
    drainExpect("R8 drain b", 8'h20, 16'h2222, 2'b10);
    loadExpect("R8 empty miss", 8'h10, 0, 16'h0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCommitDrain();
    testRollback();
    testPriority();
    testCommitSameCycle();
    testFull();
    testForward();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule